// File: doc/BRIEF.md
# Channel Command Chaining Sequencer

This block walks a channel program: a chain of 64-bit command words held in storage at consecutive 8-byte-aligned addresses. It fetches a word, presents the command code, data address and byte count to the transfer machinery, and waits for that transfer to end. When the transfer ends, it picks one of three paths. It can fetch the next word and continue the same command with a new data area. It can fetch the next word as a new command. Or it can stop and report status.

The choice depends on three flags in the current word and on how the transfer ended. The flags are chain-data, chain-command and suppress-length-indication. The transfer can end because the byte count ran out first, because the device signalled end with some count left, or because the device signalled end with a unit check. When the block stops, it emits a one-cycle status word. That word holds the address of the last command word used plus 8, the residual count, and flags for incorrect length, unit check and program check. The data movement itself and the device handshake are outside this block.

Command word layout: bits 63:56 command code, 55:32 data address, bit 31 chain-data, bit 30 chain-command, bit 29 suppress-length-indication, bits 15:0 byte count, other bits unused.

Top module: `chain_seq`

## Requirements
- R1: After reset the sequencer is idle: `busy`, `fetch_req`, `xfer_active` and `stat_valid` are all low.
- R2: A `start` whose address has any of its three low bits set causes no fetch. In the next cycle it reports status with `stat_pchk`=1, `stat_addr` = start address + 8 and `stat_count` = 0.
- R3: An aligned `start` fetches from that address, and `fetch_req` holds with a stable address until `fetch_ack`. The transfer then presents code bits 63:56, address bits 55:32 and count bits 15:0 of the fetched word.
- R4: Each chained fetch uses the previous fetch address + 8. The sum wraps modulo 2^24, so 0xFFFFF8 is followed by 0x000000.
- R5: A transfer end without device end (`xfer_dev_end`=0) while chain-data (bit 31) is set is a data chain. The next word is fetched, its address, count and flags are taken, and the command code is kept.
- R6: A device end with chain-command (bit 30) set and chain-data clear fetches the next word as a new command. This happens when there is no unit check and either no incorrect length or suppress-length-indication (bit 29) is set.
- R7: Chain-data takes precedence: a device end with chain-data set never command-chains, even with chain-command set, and ends the program.
- R8: A device end with both chain flags clear ends the program. The status address is the last used word address + 8, and `stat_count` is the residual count.
- R9: `xfer_unit_chk` with device end suppresses all chaining. The status then carries `stat_uc`=1 and the residual count.
- R10: Incorrect length means either of two things. The device may end with a nonzero residual. Or the count may have run out earlier, with chain-data clear, before the device end arrived; in that case the transfer stays active at the count-out. With bit 29 clear, incorrect length ends the program with `stat_il`=1 even when chain-command is set.
- R11: With bit 29 set, incorrect length does not stop command chaining. A program that ends without chaining reports `stat_il`=0.
- R12: `stat_valid` is a single-cycle pulse in the cycle after the ending event. `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a channel program |
| start_addr | input | 24 | Address of the first command word |
| busy | output | 1 | A program is in progress |
| fetch_req | output | 1 | Command word fetch request |
| fetch_addr | output | 24 | Address of the word being fetched |
| fetch_ack | input | 1 | Fetched word is valid |
| fetch_word | input | 64 | Fetched command word |
| xfer_active | output | 1 | A transfer is in progress |
| xfer_code | output | 8 | Command code of the transfer |
| xfer_addr | output | 24 | Data address of the transfer |
| xfer_count | output | 16 | Byte count of the transfer |
| xfer_end | input | 1 | Transfer ending event |
| xfer_dev_end | input | 1 | Event is a device end (0: count ran out) |
| xfer_residual | input | 16 | Residual byte count at the event |
| xfer_unit_chk | input | 1 | Unit check or unit exception with the device end |
| stat_valid | output | 1 | Status word pulse |
| stat_addr | output | 24 | Last used command address + 8 |
| stat_count | output | 16 | Residual count |
| stat_il | output | 1 | Incorrect length reported |
| stat_uc | output | 1 | Chaining suppressed by unit check |
| stat_pchk | output | 1 | Program check for a misaligned address |

## Verification
Unit check and incorrect length can both be true at the same device end. Incorrect length and chain-command also meet in one cycle, and so do chain-data and chain-command. The bench sweeps every flag combination against device ends with zero and nonzero residuals, with and without unit check. For each case it computes whether a chain must follow, and it checks which word is presented next or which status flags appear. An early count-out followed by a later device end is also run, to show that incorrect length is carried across the two events.

// File: rtl/chain_pkg.sv
package chain_pkg;
  localparam int WORD_W   = 64;
  localparam int CODE_W   = 8;
  localparam int ADDR_W   = 24;
  localparam int CNT_W    = 16;
  localparam int CODE_LSB = 56;
  localparam int ADDR_LSB = 32;
  localparam int CD_BIT   = 31;
  localparam int CC_BIT   = 30;
  localparam int SLI_BIT  = 29;
  localparam int CNT_LSB  = 0;
  localparam int ALIGN_W  = 3;
  localparam int STRIDE   = 1 << ALIGN_W;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_XFER} seq_state_t;
  typedef enum logic [1:0] {ACT_WAIT, ACT_DCHAIN, ACT_CCHAIN, ACT_END} chain_act_t;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [ADDR_W-1:0] addr;
    logic              cd;
    logic              cc;
    logic              sli;
    logic [CNT_W-1:0]  cnt;
  } ccw_t;
endpackage

// File: rtl/chain_rst_sync.sv
module chain_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= {q[STAGES-2:0], 1'b1};
  end
  assign rst_n_sync = q[STAGES-1];
endmodule

// File: rtl/chain_ccw_regs.sv
module chain_ccw_regs
  import chain_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              keep_code,
  input  logic [WORD_W-1:0] word,
  output ccw_t              cur
);
  ccw_t fields;
  ccw_t cur_n;

  always_comb begin
    fields.code = word[CODE_LSB +: CODE_W];
    fields.addr = word[ADDR_LSB +: ADDR_W];
    fields.cd   = word[CD_BIT];
    fields.cc   = word[CC_BIT];
    fields.sli  = word[SLI_BIT];
    fields.cnt  = word[CNT_LSB +: CNT_W];
  end

  always_comb begin
    cur_n = cur;
    if (load) begin
      cur_n = fields;
      if (keep_code) cur_n.code = cur.code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else        cur <= cur_n;
  end
endmodule

// File: rtl/chain_decide.sv
module chain_decide
  import chain_pkg::*;
(
  input  logic             cd,
  input  logic             cc,
  input  logic             sli,
  input  logic             dev_end,
  input  logic [CNT_W-1:0] residual,
  input  logic             unit_chk,
  input  logic             overrun,
  output chain_act_t       act,
  output logic             rep_il
);
  logic len_bad;

  always_comb begin
    len_bad = overrun || (residual != '0);
    act     = ACT_END;
    rep_il  = 1'b0;
    if (!dev_end) begin
      act = cd ? ACT_DCHAIN : ACT_WAIT;
    end else begin
      rep_il = len_bad && !sli;
      if (unit_chk)              act = ACT_END;
      else if (len_bad && !sli)  act = ACT_END;
      else if (!cd && cc)        act = ACT_CCHAIN;
      else                       act = ACT_END;
    end
  end
endmodule

// File: rtl/chain_seq.sv
module chain_seq
  import chain_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              busy,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_ack,
  input  logic [WORD_W-1:0] fetch_word,
  output logic              xfer_active,
  output logic [CODE_W-1:0] xfer_code,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic [CNT_W-1:0]  xfer_count,
  input  logic              xfer_end,
  input  logic              xfer_dev_end,
  input  logic [CNT_W-1:0]  xfer_residual,
  input  logic              xfer_unit_chk,
  output logic              stat_valid,
  output logic [ADDR_W-1:0] stat_addr,
  output logic [CNT_W-1:0]  stat_count,
  output logic              stat_il,
  output logic              stat_uc,
  output logic              stat_pchk
);
  logic        rst_s_n;
  seq_state_t  state, state_n;
  logic        data_mode, data_mode_n;
  logic        overrun, overrun_n;
  logic [ADDR_W-1:0] faddr, faddr_n;
  logic        word_load;
  logic        end_now, end_pchk;
  chain_act_t  act;
  logic        rep_il;
  ccw_t        cur;
  logic        sv_n;
  logic [ADDR_W-1:0] sa_n;
  logic [CNT_W-1:0]  sc_n;
  logic        sil_n, suc_n, spc_n;

  chain_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s_n)
  );

  chain_ccw_regs u_regs (
    .clk(clk), .rst_n(rst_s_n), .load(word_load), .keep_code(data_mode),
    .word(fetch_word), .cur(cur)
  );

  chain_decide u_dec (
    .cd(cur.cd), .cc(cur.cc), .sli(cur.sli), .dev_end(xfer_dev_end),
    .residual(xfer_residual), .unit_chk(xfer_unit_chk), .overrun(overrun),
    .act(act), .rep_il(rep_il)
  );

  always_comb begin
    state_n     = state;
    data_mode_n = data_mode;
    overrun_n   = overrun;
    faddr_n     = faddr;
    word_load   = 1'b0;
    end_now     = 1'b0;
    end_pchk    = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        if (start_addr[ALIGN_W-1:0] != '0) begin
          end_now  = 1'b1;
          end_pchk = 1'b1;
        end else begin
          faddr_n     = start_addr;
          data_mode_n = 1'b0;
          state_n     = ST_FETCH;
        end
      end
      ST_FETCH: if (fetch_ack) begin
        word_load = 1'b1;
        overrun_n = 1'b0;
        state_n   = ST_XFER;
      end
      ST_XFER: if (xfer_end) begin
        unique case (act)
          ACT_WAIT:   overrun_n = 1'b1;
          ACT_DCHAIN: begin
            faddr_n = faddr + ADDR_W'(STRIDE); data_mode_n = 1'b1; state_n = ST_FETCH;
          end
          ACT_CCHAIN: begin
            faddr_n = faddr + ADDR_W'(STRIDE); data_mode_n = 1'b0; state_n = ST_FETCH;
          end
          default: begin end_now = 1'b1; state_n = ST_IDLE; end
        endcase
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_comb begin
    sv_n  = end_now;
    sa_n  = stat_addr;
    sc_n  = stat_count;
    sil_n = stat_il;
    suc_n = stat_uc;
    spc_n = stat_pchk;
    if (end_now) begin
      sa_n  = (end_pchk ? start_addr : faddr) + ADDR_W'(STRIDE);
      sc_n  = end_pchk ? '0 : xfer_residual;
      sil_n = !end_pchk && rep_il;
      suc_n = !end_pchk && xfer_unit_chk;
      spc_n = end_pchk;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state      <= ST_IDLE;
      data_mode  <= 1'b0;
      overrun    <= 1'b0;
      faddr      <= '0;
      stat_valid <= 1'b0;
      stat_addr  <= '0;
      stat_count <= '0;
      stat_il    <= 1'b0;
      stat_uc    <= 1'b0;
      stat_pchk  <= 1'b0;
    end else begin
      state      <= state_n;
      data_mode  <= data_mode_n;
      overrun    <= overrun_n;
      faddr      <= faddr_n;
      stat_valid <= sv_n;
      stat_addr  <= sa_n;
      stat_count <= sc_n;
      stat_il    <= sil_n;
      stat_uc    <= suc_n;
      stat_pchk  <= spc_n;
    end
  end

  assign busy        = (state != ST_IDLE);
  assign fetch_req   = (state == ST_FETCH);
  assign fetch_addr  = faddr;
  assign xfer_active = (state == ST_XFER);
  assign xfer_code   = cur.code;
  assign xfer_addr   = cur.addr;
  assign xfer_count  = cur.cnt;

  a_r2_misalign_no_fetch: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!busy && start && start_addr[ALIGN_W-1:0] != '0) |=> (!fetch_req && stat_valid && stat_pchk));
  a_r3_fetch_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    (fetch_req && !fetch_ack) |=> (fetch_req && $stable(fetch_addr)));
  a_r4_fetch_aligned: assert property (@(posedge clk) disable iff (!rst_s_n)
    fetch_req |-> (fetch_addr[ALIGN_W-1:0] == '0));
  a_r5_dchain_fetch: assert property (@(posedge clk) disable iff (!rst_s_n)
    (xfer_active && xfer_end && !xfer_dev_end && cur.cd) |=> (fetch_req && !stat_valid));
  a_r7_cd_precedence: assert property (@(posedge clk) disable iff (!rst_s_n)
    (xfer_active && xfer_end && xfer_dev_end && cur.cd) |=> (!fetch_req && stat_valid));
  a_r9_uc_stops: assert property (@(posedge clk) disable iff (!rst_s_n)
    (xfer_active && xfer_end && xfer_dev_end && xfer_unit_chk) |=> (stat_valid && stat_uc && !busy));
  a_r10_il_stops: assert property (@(posedge clk) disable iff (!rst_s_n)
    (xfer_active && xfer_end && xfer_dev_end && !cur.sli && xfer_residual != '0)
      |=> (stat_valid && stat_il));
  a_r12_stat_pulse: assert property (@(posedge clk) disable iff (!rst_s_n)
    stat_valid |=> !stat_valid);
endmodule

// File: tb/sim_chain_seq.sv
module sim_chain_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] start_addr = '0;
  logic        busy, fetch_req, fetch_ack, xfer_active;
  logic [23:0] fetch_addr, xfer_addr, stat_addr;
  logic [63:0] fetch_word;
  logic [7:0]  xfer_code;
  logic [15:0] xfer_count, stat_count;
  logic        xfer_end = 1'b0, xfer_dev_end = 1'b0, xfer_unit_chk = 1'b0;
  logic [15:0] xfer_residual = '0;
  logic        stat_valid, stat_il, stat_uc, stat_pchk;

  logic [63:0] mem [16];
  logic [23:0] last_fetch;
  int tests = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  chain_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .busy(busy),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ack(fetch_ack),
    .fetch_word(fetch_word), .xfer_active(xfer_active), .xfer_code(xfer_code),
    .xfer_addr(xfer_addr), .xfer_count(xfer_count), .xfer_end(xfer_end),
    .xfer_dev_end(xfer_dev_end), .xfer_residual(xfer_residual),
    .xfer_unit_chk(xfer_unit_chk), .stat_valid(stat_valid), .stat_addr(stat_addr),
    .stat_count(stat_count), .stat_il(stat_il), .stat_uc(stat_uc), .stat_pchk(stat_pchk)
  );

  initial begin fetch_ack = 1'b0; fetch_word = '0; last_fetch = '0; end
  always @(negedge clk) begin
    if (fetch_req && !fetch_ack) begin
      fetch_ack  = 1'b1;
      fetch_word = mem[fetch_addr[6:3]];
      last_fetch = fetch_addr;
    end else fetch_ack = 1'b0;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog expired: got %0d cycles, expected below 100000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic logic [63:0] mk(input logic [7:0] c, input logic [23:0] a,
                                     input logic cd, input logic cc, input logic sli,
                                     input logic [15:0] n);
    return {c, a, cd, cc, sli, 13'd0, n};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic pulse_start(input logic [23:0] a);
    @(negedge clk); start = 1'b1; start_addr = a;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_xfer();
    for (int i = 0; i < 20 && !xfer_active; i++) @(negedge clk);
  endtask

  task automatic end_xfer(input logic de, input logic [15:0] res, input logic uc);
    @(negedge clk); xfer_end = 1'b1; xfer_dev_end = de; xfer_residual = res; xfer_unit_chk = uc;
    @(negedge clk); xfer_end = 1'b0; xfer_dev_end = 1'b0; xfer_residual = '0; xfer_unit_chk = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 fetch_req", fetch_req, 0);
    chk("R1 xfer_active", xfer_active, 0);
    chk("R1 stat_valid", stat_valid, 0);

    // sweep: flags x residual x unit check at device end
    for (int f = 0; f < 8; f++) begin
      for (int u = 0; u < 2; u++) begin
        for (int r = 0; r < 2; r++) begin
          logic cd, cc, sli, il, chain;
          logic [7:0] c0;
          logic [23:0] a0;
          logic [15:0] n0, res;
          cd = f[2]; cc = f[1]; sli = f[0];
          c0 = 8'(8'h10 + f * 4 + u * 2 + r);
          a0 = 24'(24'h001000 + f * 64 + u * 16 + r);
          n0 = 16'(16'h0040 + f);
          res = r ? 16'd5 : 16'd0;
          mem[2] = mk(c0, a0, cd, cc, sli, n0);
          mem[3] = mk(8'hEE, 24'h0ABCDE, 1'b0, 1'b0, 1'b0, 16'h0077);
          pulse_start(24'h000010);
          wait_xfer();
          chk("R3 code", xfer_code, c0);
          chk("R3 addr", xfer_addr, a0);
          chk("R3 count", xfer_count, n0);
          il = (res != 0);
          chain = !u && !(il && !sli) && !cd && cc;
          end_xfer(1'b1, res, u[0]);
          if (chain) begin
            chk("R6 no status on chain", stat_valid, 0);
            wait_xfer();
            chk("R6 new code", xfer_code, 8'hEE);
            chk("R6 new count", xfer_count, 16'h0077);
            chk("R4 next fetch", last_fetch, 24'h000018);
            end_xfer(1'b1, 16'd0, 1'b0);
            chk("R8 status after chain", stat_valid, 1);
            chk("R8 addr after chain", stat_addr, 24'h000020);
            chk("R11 il after chain", stat_il, 0);
          end else begin
            chk(cd && cc ? "R7 end on cd precedence" : "R8 end", stat_valid, 1);
            chk("R8 addr", stat_addr, 24'h000018);
            chk("R9 residual", stat_count, res);
            chk(sli ? "R11 il suppressed" : "R10 il", stat_il, il && !sli);
            chk("R9 uc", stat_uc, u);
            chk("R2 pchk clear", stat_pchk, 0);
          end
          @(negedge clk);
        end
      end
    end

    // data chain keeps code
    mem[4] = mk(8'hA1, 24'h002000, 1'b1, 1'b0, 1'b0, 16'h0010);
    mem[5] = mk(8'hB2, 24'h003000, 1'b0, 1'b0, 1'b0, 16'h0020);
    pulse_start(24'h000020);
    wait_xfer();
    end_xfer(1'b0, 16'd0, 1'b0);
    chk("R5 no status", stat_valid, 0);
    wait_xfer();
    chk("R5 code kept", xfer_code, 8'hA1);
    chk("R5 new addr", xfer_addr, 24'h003000);
    chk("R5 new count", xfer_count, 16'h0020);
    end_xfer(1'b1, 16'd0, 1'b0);
    chk("R5 end addr", stat_addr, 24'h000030);
    chk("R5 end il", stat_il, 0);

    // count-out without chain-data, then device end
    mem[6] = mk(8'hC3, 24'h004000, 1'b0, 1'b1, 1'b0, 16'h0008);
    pulse_start(24'h000030);
    wait_xfer();
    end_xfer(1'b0, 16'd0, 1'b0);
    chk("R10 still active", xfer_active, 1);
    chk("R10 no status yet", stat_valid, 0);
    end_xfer(1'b1, 16'd0, 1'b0);
    chk("R10 il status", stat_valid, 1);
    chk("R10 il flag", stat_il, 1);
    chk("R10 addr no chain", stat_addr, 24'h000038);

    // misaligned start
    pulse_start(24'h000044);
    chk("R2 status", stat_valid, 1);
    chk("R2 pchk", stat_pchk, 1);
    chk("R2 addr", stat_addr, 24'h00004C);
    chk("R2 count", stat_count, 0);
    chk("R2 no fetch", fetch_req, 0);
    @(negedge clk);

    // wrap of fetch address
    mem[15] = mk(8'hD4, 24'h005000, 1'b0, 1'b1, 1'b0, 16'h0001);
    mem[0]  = mk(8'hE5, 24'h006000, 1'b0, 1'b0, 1'b0, 16'h0002);
    pulse_start(24'hFFFFF8);
    wait_xfer();
    chk("R4 top fetch", last_fetch, 24'hFFFFF8);
    end_xfer(1'b1, 16'd0, 1'b0);
    wait_xfer();
    chk("R4 wrapped fetch", last_fetch, 24'h000000);
    chk("R6 wrapped code", xfer_code, 8'hE5);
    end_xfer(1'b1, 16'd0, 1'b0);
    chk("R4 wrapped status", stat_addr, 24'h000008);

    // start while busy is ignored
    mem[2] = mk(8'h55, 24'h007000, 1'b0, 1'b0, 1'b0, 16'h0003);
    pulse_start(24'h000010);
    wait_xfer();
    pulse_start(24'h000028);
    chk("R12 still on first word", xfer_code, 8'h55);
    end_xfer(1'b1, 16'd0, 1'b0);
    chk("R12 status addr", stat_addr, 24'h000018);
    chk("R12 last fetch", last_fetch, 24'h000010);
    @(negedge clk);
    chk("R12 pulse ends", stat_valid, 0);
    chk("R12 idle", busy, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule